// File: doc/BRIEF.md
# Serial Receive Deframer with Sticky Error Status

This block turns an asynchronous serial line into characters. It samples the line on a 16x oversampling tick, checks that each start bit is real, and takes every data, parity and stop bit near the middle of its bit period. Each finished character goes to a downstream receive FIFO as one push. The push carries the data byte and four error flags.

The character format is set by configuration inputs that the transmitter uses as well: a data length of five to eight bits and one of five parity modes. The block also keeps a sticky error status. This is a four-bit value that gathers every error seen since it was last cleared. A single clear pulse wipes the whole status, whichever bits are set.

A receive DMA request is derived from a FIFO-not-empty input. When the halt-on-error option is on, the request is held low while any error is pending.

Top module: `serial_rx_deframer`

## Requirements
- R1: After reset, push_valid is low, err_status is 0 and dma_req is low, with the line idle high.
- R2: A falling edge starts a character only if the line is still low at the 8th sample tick after it is seen. A low pulse of 3 ticks produces no push.
- R3: Data bits arrive LSB first. word_len codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits above the selected length read as zero in push_data.
- R4: par_mode codes are 0 for none, 1 for even, 2 for odd, 3 for a parity bit that is always one, and 4 for a parity bit that is always zero. A received parity bit that differs from the expected one sets error bit 1.
- R5: A low level at the first stop bit sets error bit 0 (framing). After such a character, no new start is taken until the line has been seen high.
- R6: A line held low through the whole frame (start, data, parity and stop) produces exactly one push. That push has data 0, error bits 0 and 2 set, and error bit 1 clear.
- R7: A character that completes while fifo_full is high is not pushed. err_status bit 3 (overrun) is set at once, without waiting for a later read. The next character that is pushed carries error bit 3.
- R8: err_status bits are framing at bit 0, parity at bit 1, break at bit 2 and overrun at bit 3. Each bit is sticky. It takes the OR of the error bits of every pushed character and every overrun, one clock after the event.
- R9: A one-clock err_clr pulse clears every status bit. If an error is recorded in the same clock as the clear, that error's bits stay set.
- R10: dma_req equals dma_en AND rx_avail. It is forced low while dma_halt_on_err is high and any err_status bit is set.
- R11: Bits are sampled only on smp_tick clocks. Each character's push_valid lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick | input | 1 | Enable at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| word_len | input | 2 | Data length code (0 to 3 for 5 to 8 bits) |
| par_mode | input | 3 | Parity mode code |
| fifo_full | input | 1 | Receive FIFO cannot accept a push |
| err_clr | input | 1 | Bus write strobe that clears all status bits |
| dma_en | input | 1 | Receive DMA enabled |
| dma_halt_on_err | input | 1 | Hold the DMA request low while an error is pending |
| rx_avail | input | 1 | Receive FIFO holds data |
| push_valid | output | 1 | One-clock push strobe to the FIFO |
| push_data | output | 8 | Received character |
| push_err | output | 4 | Error flags stored with the character |
| err_status | output | 4 | Sticky error status, read by the bus |
| dma_req | output | 1 | Receive DMA request |

## Verification
A bus clear can arrive in the same clock that a character's errors are recorded into the status. The bench provokes this by watching for a push and raising err_clr for exactly that clock, on a character sent with a bad parity bit. The clock after, err_status must equal only that character's error bits. Zero would mean the clear won, and keeping the older bits would mean the clear was lost.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        PM_OFF  = 3'd0,
        PM_EVEN = 3'd1,
        PM_ODD  = 3'd2,
        PM_HIGH = 3'd3,
        PM_LOW  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    localparam int ERR_W   = 4;
    localparam int ERR_FRM = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_BRK = 2;
    localparam int ERR_OVR = 3;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] sr_d, sr_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sr_d = line_in;
        end else begin : g_chain
            always_comb sr_d = {sr_q[STAGES-2:0], line_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign line_out = sr_q[STAGES-1];
endmodule

// File: rtl/rx_parity_ref.sv
module rx_parity_ref
    import serial_rx_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       data_xor,
    output logic       enabled,
    output logic       exp_bit
);
    always_comb begin
        enabled = 1'b1;
        exp_bit = 1'b0;
        case (par_mode_e'(mode))
            PM_EVEN: exp_bit = data_xor;
            PM_ODD:  exp_bit = ~data_xor;
            PM_HIGH: exp_bit = 1'b1;
            PM_LOW:  exp_bit = 1'b0;
            default: enabled = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_deframe_core.sv
module rx_deframe_core
    import serial_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int OVS      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic [1:0]        len_code,
    input  logic [2:0]        par_mode,
    input  logic              fifo_full,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic [ERR_W-1:0]  push_err,
    output logic              ovr_evt
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              par_acc;
        logic              par_bad;
        logic              all_low;
        logic              ovr_pend;
        logic              push;
        logic [DATA_W-1:0] pdata;
        logic [ERR_W-1:0]  perr;
        logic              ovr_evt;
    } core_t;

    core_t q, d;

    logic             par_en, par_exp;
    logic [IDX_W-1:0] last_idx;
    logic             is_brk;

    rx_parity_ref u_par (
        .mode     (par_mode),
        .data_xor (q.par_acc),
        .enabled  (par_en),
        .exp_bit  (par_exp)
    );

    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(len_code);
    assign is_brk   = q.all_low & ~rx;

    always_comb begin
        d         = q;
        d.push    = 1'b0;
        d.ovr_evt = 1'b0;
        if (tick) begin
            case (q.st)
                ST_IDLE: begin
                    if (!rx) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == MID_CNT) begin
                        d.cnt = '0;
                        if (rx) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st      = ST_DATA;
                            d.idx     = '0;
                            d.data    = '0;
                            d.par_acc = 1'b0;
                            d.par_bad = 1'b0;
                            d.all_low = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == END_CNT) begin
                        d.cnt         = '0;
                        d.data[q.idx] = rx;
                        d.par_acc     = q.par_acc ^ rx;
                        d.all_low     = q.all_low & ~rx;
                        if (q.idx == last_idx) d.st = par_en ? ST_PAR : ST_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (q.cnt == END_CNT) begin
                        d.cnt     = '0;
                        d.par_bad = (rx != par_exp);
                        d.all_low = q.all_low & ~rx;
                        d.st      = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == END_CNT) begin
                        d.cnt = '0;
                        d.st  = rx ? ST_IDLE : ST_HOLD;
                        if (fifo_full) begin
                            d.ovr_evt  = 1'b1;
                            d.ovr_pend = 1'b1;
                        end else begin
                            d.push              = 1'b1;
                            d.pdata             = is_brk ? '0 : q.data;
                            d.perr              = '0;
                            d.perr[ERR_FRM]     = ~rx;
                            d.perr[ERR_PAR]     = q.par_bad & ~is_brk;
                            d.perr[ERR_BRK]     = is_brk;
                            d.perr[ERR_OVR]     = q.ovr_pend;
                            d.ovr_pend          = 1'b0;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rx) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push      = q.push;
    assign push_data = q.pdata;
    assign push_err  = q.perr;
    assign ovr_evt   = q.ovr_evt;

    assert_push_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !$past(fifo_full));

    assert_break_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_err[ERR_BRK]) |-> (push_data == '0 && push_err[ERR_FRM] && !push_err[ERR_PAR]));

    assert_push_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    assert_no_push_untick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push) |-> $past(tick));

endmodule

// File: rtl/rx_err_sticky.sv
module rx_err_sticky
    import serial_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set_vec,
    input  logic             clr,
    output logic [ERR_W-1:0] status
);
    logic [ERR_W-1:0] status_d, status_q;

    always_comb status_d = (clr ? '0 : status_q) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> (status == '0));

    assert_sticky_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status)));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
    import serial_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int OVS         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick,
    input  logic              rx_in,
    input  logic [1:0]        word_len,
    input  logic [2:0]        par_mode,
    input  logic              fifo_full,
    input  logic              err_clr,
    input  logic              dma_en,
    input  logic              dma_halt_on_err,
    input  logic              rx_avail,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic [3:0]        push_err,
    output logic [3:0]        err_status,
    output logic              dma_req
);
    logic             rx_s;
    logic             ovr_evt;
    logic [ERR_W-1:0] set_vec;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (rx_in),
        .line_out (rx_s)
    );

    rx_deframe_core #(.DATA_W(DATA_W), .MIN_BITS(5), .OVS(OVS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (smp_tick),
        .rx        (rx_s),
        .len_code  (word_len),
        .par_mode  (par_mode),
        .fifo_full (fifo_full),
        .push      (push_valid),
        .push_data (push_data),
        .push_err  (push_err),
        .ovr_evt   (ovr_evt)
    );

    always_comb begin
        set_vec = push_valid ? push_err : '0;
        if (ovr_evt) set_vec[ERR_OVR] = 1'b1;
    end

    rx_err_sticky u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr     (err_clr),
        .status  (err_status)
    );

    assign dma_req = dma_en & rx_avail & ~(dma_halt_on_err & (|err_status));

    assert_dma_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_halt_on_err && err_status != '0) |-> !dma_req);

endmodule

// File: tb/test_serial_rx_deframer.sv
module test_serial_rx_deframer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic [2:0] par_mode = 3'd0;
    logic       fifo_full = 1'b0;
    logic       err_clr = 1'b0;
    logic       dma_en = 1'b0;
    logic       dma_halt_on_err = 1'b0;
    logic       rx_avail = 1'b0;
    logic       push_valid;
    logic [7:0] push_data;
    logic [3:0] push_err;
    logic [3:0] err_status;
    logic       dma_req;

    int total = 0;
    int bad = 0;
    int pushes = 0;
    logic [11:0] exp_q[$];
    logic [3:0]  exp_status = 4'h0;
    logic        pend_ovr = 1'b0;
    logic        arm_clr = 1'b0;
    logic        done = 1'b0;

    localparam int BIT_CLKS = 32;

    always #4 clk = ~clk;

    serial_rx_deframer i_serial_rx_deframer (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .rx_in(rx_in),
        .word_len(word_len), .par_mode(par_mode), .fifo_full(fifo_full),
        .err_clr(err_clr), .dma_en(dma_en), .dma_halt_on_err(dma_halt_on_err),
        .rx_avail(rx_avail), .push_valid(push_valid), .push_data(push_data),
        .push_err(push_err), .err_status(err_status), .dma_req(dma_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample tick every second clock (R11).
    initial forever begin
        @(negedge clk);
        smp_tick = ~smp_tick;
    end

    // Push comparison on every clock against the expected queue (R3 R4 R5 R6 R7).
    initial forever begin
        @(negedge clk);
        if (rst_n && push_valid) begin
            pushes++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected push", {push_err, push_data}, 0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check({push_err, push_data} == e, "R3/R4/R5/R6/R7 push", {push_err, push_data}, e);
            end
        end
    end

    // Clear aimed at the clock of a push (R9 collision).
    initial forever begin
        @(negedge clk);
        if (arm_clr && push_valid) begin
            err_clr = 1'b1;
            arm_clr = 1'b0;
            @(negedge clk);
            err_clr = 1'b0;
        end
    end

    function automatic logic par_bit(input logic [2:0] m, input logic [7:0] v);
        case (m)
            3'd1: return ^v;
            3'd2: return ~^v;
            3'd3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic line_bit(input logic v);
        rx_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] data, input logic flip, input logic stop_low, input logic collide);
        int n;
        logic [7:0] m;
        logic pb, brk;
        logic [3:0] e;
        n = 5 + int'(word_len);
        m = data & 8'((1 << n) - 1);
        pb = par_bit(par_mode, m) ^ flip;
        brk = stop_low && (m == 0) && (par_mode == 3'd0 || pb == 1'b0);
        e = {pend_ovr, brk, flip && (par_mode != 3'd0) && !brk, stop_low};
        if (fifo_full) begin
            pend_ovr = 1'b1;
            exp_status |= 4'h8;
        end else begin
            exp_q.push_back({e, brk ? 8'h00 : m});
            exp_status = collide ? e : (exp_status | e);
            pend_ovr = 1'b0;
        end
        arm_clr = collide;
        line_bit(1'b0);
        for (int i = 0; i < n; i++) line_bit(m[i]);
        if (par_mode != 3'd0) line_bit(pb);
        line_bit(!stop_low);
        line_bit(1'b1);
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic status_chk(input string req);
        check(err_status == exp_status, req, err_status, exp_status);
    endtask

    task automatic clear_all();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        exp_status = 4'h0;
        @(negedge clk);
    endtask

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        check(push_valid == 1'b0, "R1 push idle", push_valid, 0);
        check(err_status == 4'h0, "R1 status", err_status, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(dma_req == 1'b0, "R1 dma idle", dma_req, 0);

        // R3: 8 bits, no parity
        word_len = 2'd3; par_mode = 3'd0;
        frame(8'hA5, 0, 0, 0);
        status_chk("R8 clean frame");
        // R3 R4: other lengths and parity modes
        word_len = 2'd2; par_mode = 3'd1; frame(8'h5B, 0, 0, 0);
        word_len = 2'd0; par_mode = 3'd2; frame(8'hF3, 0, 0, 0);
        word_len = 2'd1; par_mode = 3'd3; frame(8'h2C, 0, 0, 0);
        word_len = 2'd3; par_mode = 3'd4; frame(8'h81, 0, 0, 0);
        status_chk("R4 good parity no error");
        // R4 parity error
        word_len = 2'd3; par_mode = 3'd1; frame(8'h37, 1, 0, 0);
        status_chk("R4 parity error status");
        word_len = 2'd0; par_mode = 3'd3; frame(8'h0A, 1, 0, 0);
        status_chk("R4 stick parity error");
        clear_all();
        status_chk("R9 clear");
        // R5 framing
        par_mode = 3'd0; word_len = 2'd3;
        frame(8'h3C, 0, 1, 0);
        status_chk("R5 framing status");
        // R6 break: whole frame low, then long low
        exp_q.push_back({pend_ovr, 3'b101, 8'h00});
        exp_status |= 4'h5;
        p0 = pushes;
        rx_in = 1'b0;
        repeat (14 * BIT_CLKS) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        check(pushes == p0 + 1, "R6 single break push", pushes - p0, 1);
        status_chk("R6 break status");
        clear_all();
        // R2 glitch
        p0 = pushes;
        rx_in = 1'b0;
        repeat (6) @(negedge clk);
        rx_in = 1'b1;
        repeat (4 * BIT_CLKS) @(negedge clk);
        check(pushes == p0, "R2 glitch rejected", pushes - p0, 0);
        frame(8'h69, 0, 0, 0);
        check(pushes == p0 + 1, "R2 start after glitch", pushes - p0, 1);
        // R7 overrun
        fifo_full = 1'b1;
        p0 = pushes;
        frame(8'h11, 0, 0, 0);
        fifo_full = 1'b0;
        check(pushes == p0, "R7 no push when full", pushes - p0, 0);
        status_chk("R7 overrun status immediate");
        // R10 dma
        dma_en = 1'b1; rx_avail = 1'b1; dma_halt_on_err = 1'b1;
        @(negedge clk);
        check(dma_req == 1'b0, "R10 halted by error", dma_req, 0);
        dma_halt_on_err = 1'b0;
        @(negedge clk);
        check(dma_req == 1'b1, "R10 no halt option", dma_req, 1);
        clear_all();
        dma_halt_on_err = 1'b1;
        @(negedge clk);
        check(dma_req == 1'b1, "R10 running after clear", dma_req, 1);
        rx_avail = 1'b0;
        @(negedge clk);
        check(dma_req == 1'b0, "R10 empty fifo", dma_req, 0);
        // R7 next char carries overrun
        frame(8'h42, 0, 0, 0);
        status_chk("R7 overrun carried");
        // R9 clear in same clock as new error
        par_mode = 3'd2;
        frame(8'h77, 1, 0, 1);
        status_chk("R9 set wins over clear");
        check(exp_q.size() == 0, "R11 all pushes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule